// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns a one-bit oversampled modulator stream into 24-bit conversion words. It is a third-order sinc (cascaded integrator-comb) decimator. A 12-bit ratio code sets how many accepted modulator samples make up one output period. A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. Three wrapping integrators run at the sample rate. Three first-difference combs run once per output period. The result is scaled to 24 bits and then coded as offset binary or as clamped unipolar.

A synchronising input holds every integrator, comb, counter and the settling tracker cleared. The system asserts it on a channel change or whenever filtering must restart. While it is high, the block copies the ratio code, so a new ratio never mixes with the old one inside a word. Words are only announced once the sinc3 window has filled completely after a restart, which takes three output periods. The sample-enable input is the modulator-rate clock enable. Any clock division that produces it lies outside this block.

Top module: `sinc3_decim`

## Requirements
- R1: After reset `word_o` is 0 and `word_stb_o` is 0. The ratio in force is 320 (0x140), so without any sync the first strobe comes on the 960th accepted sample.
- R2: Let N be the ratio and let x be +1 for bit 1 and -1 for bit 0. Each announced word carries D, the N-sample moving sum applied three times to x, taken at the last sample of an output period. The history before the last sync counts as zero.
- R3: Once settled, `word_stb_o` is high for exactly one cycle per N accepted samples. It rises in the cycle after the N-th sample of the period is taken, and it is never high at any other time.
- R4: While `sync_i` is high, no samples are taken and no strobe occurs. After release, the first strobe follows the 3N-th accepted sample.
- R5: `code_i` is captured only in cycles with `sync_i` high. Changing it at other times has no effect on the cadence.
- R6: With `unipolar_i` = 0, the word is offset binary: 0x800000 + floor(D / 2^13), which is D bits [36:13] with the top bit inverted.
- R7: With `unipolar_i` = 1, the word is D bits [35:12] when D >= 0 and 0 when D < 0. The format is taken in the cycle in which the period's last sample is accepted.
- R8: After a step in the input that is not aligned to a sync, the fourth announced word after the step depends only on post-step samples.
- R9: Cycles with `samp_en_i` low advance neither the filter nor the period counter.
- R10: `word_o` changes only together with a strobe. It holds through gaps and through sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Filter restart; clears state and captures the ratio code |
| code_i | input | 12 | Decimation ratio code, legal range 19 to 4000 |
| unipolar_i | input | 1 | Output coding: 0 offset binary, 1 unipolar clamped |
| samp_en_i | input | 1 | Modulator sample enable |
| samp_bit_i | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| word_o | output | 24 | Last announced conversion word |
| word_stb_o | output | 1 | One-cycle pulse marking a new settled word |

## Verification
The hardest situation to reach is a step in the input that falls at an arbitrary phase inside an output period with no sync. The bench gets there by holding the bit constant for many periods at a large ratio. It then switches the bit after an odd number of extra samples, so the step lands partway through a period, and checks the fourth word after it against the full-scale value. Two other cases need long constant runs and are reached the same way: the extreme ratio of 4000 and the clamp to zero in unipolar mode. Irregular sample-enable gaps and code changes made without sync are mixed in, and a behavioural moving-sum model checks every cycle.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned FILT_ORDER   = 3;
  localparam int unsigned RATIO_BITS   = 12;
  localparam int unsigned WORD_BITS    = 24;
  localparam int unsigned SETTLE_PRDS  = 3;
  localparam logic [11:0] RATIO_RESET  = 12'h140;

  typedef enum logic {
    FMT_OFFSET_BIN = 1'b0,
    FMT_UNIPOLAR   = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/sinc3_rst_sync.sv
module sinc3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned ACC_W = 37,
  parameter int unsigned ORDER = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0]            x_ext;
  logic [ORDER-1:0][ACC_W-1:0] acc_sum;

  // bit 1 -> +1, bit 0 -> -1 in two's complement
  assign x_ext = {{(ACC_W-1){~bit_i}}, 1'b1};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] in_v;
    logic [ACC_W-1:0] acc_q, acc_d;

    if (g == 0) begin : g_first
      assign in_v = x_ext;
    end else begin : g_rest
      assign in_v = acc_sum[g-1];
    end

    assign acc_sum[g] = acc_q + in_v;

    always_comb begin
      acc_d = acc_q;
      if (clr_i)     acc_d = '0;
      else if (en_i) acc_d = acc_sum[g];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else         acc_q <= acc_d;
    end
  end

  assign sum_o = acc_sum[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ACC_W = 37,
  parameter int unsigned ORDER = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dec_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o
);
  logic [ORDER-1:0][ACC_W-1:0] diff;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] in_v;
    logic [ACC_W-1:0] dly_q, dly_d;

    if (g == 0) begin : g_first
      assign in_v = din_i;
    end else begin : g_rest
      assign in_v = diff[g-1];
    end

    assign diff[g] = in_v - dly_q;

    always_comb begin
      dly_d = dly_q;
      if (clr_i)      dly_d = '0;
      else if (dec_i) dly_d = in_v;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) dly_q <= '0;
      else         dly_q <= dly_d;
    end
  end

  assign dout_o = diff[ORDER-1];
endmodule

// File: rtl/sinc3_dec_ctrl.sv
module sinc3_dec_ctrl #(
  parameter int unsigned   CODE_W   = 12,
  parameter int unsigned   SETTLE   = 3,
  parameter logic [CODE_W-1:0] RST_CODE = 12'h140
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              dec_o,
  output logic              emit_o
);
  localparam int unsigned SET_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic [CODE_W-1:0] cnt_q, cnt_d, code_q, code_d;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic              last, settled;

  assign last    = (cnt_q == code_q - CODE_W'(1));
  assign settled = (settle_q == SET_W'(SETTLE - 1));

  always_comb begin
    cnt_d    = cnt_q;
    settle_d = settle_q;
    code_d   = code_q;
    if (sync_i) begin
      cnt_d    = '0;
      settle_d = '0;
      code_d   = code_i;
    end else if (en_i) begin
      if (last) begin
        cnt_d = '0;
        if (!settled) settle_d = settle_q + SET_W'(1);
      end else begin
        cnt_d = cnt_q + CODE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      settle_q <= '0;
      code_q   <= RST_CODE;
    end else begin
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      code_q   <= code_d;
    end
  end

  assign code_o = code_q;
  assign dec_o  = en_i && !sync_i && last;
  assign emit_o = dec_o && settled;
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int unsigned CODE_W = RATIO_BITS,
  parameter int unsigned OUT_W  = WORD_BITS,
  parameter int unsigned ORDER  = FILT_ORDER,
  parameter int unsigned SETTLE = SETTLE_PRDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              unipolar_i,
  input  logic              samp_en_i,
  input  logic              samp_bit_i,
  output logic [OUT_W-1:0]  word_o,
  output logic              word_stb_o
);
  localparam int unsigned ACC_W = ORDER * CODE_W + 1;

  logic              rst_ni;
  logic [CODE_W-1:0] code_q;
  logic              dec, emit;
  logic [ACC_W-1:0]  integ_sum, filt_d;
  logic [OUT_W-1:0]  fmt_word, word_q, word_d;
  logic              stb_q, stb_d;
  out_fmt_e          fmt_sel;
  logic              unused_low;

  sinc3_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_no(rst_ni)
  );

  sinc3_dec_ctrl #(.CODE_W(CODE_W), .SETTLE(SETTLE),
                   .RST_CODE(CODE_W'(RATIO_RESET))) u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .sync_i(sync_i), .en_i(samp_en_i),
    .code_i(code_i), .code_o(code_q), .dec_o(dec), .emit_o(emit)
  );

  sinc3_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_ni(rst_ni), .clr_i(sync_i),
    .en_i(samp_en_i), .bit_i(samp_bit_i), .sum_o(integ_sum)
  );

  sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_ni(rst_ni), .clr_i(sync_i),
    .dec_i(dec), .din_i(integ_sum), .dout_o(filt_d)
  );

  assign fmt_sel    = out_fmt_e'(unipolar_i);
  assign unused_low = ^filt_d[ACC_W-OUT_W-2:0];

  // Top OUT_W bits of the signed full-scale range
  always_comb begin
    if (fmt_sel == FMT_UNIPOLAR)
      fmt_word = filt_d[ACC_W-1] ? '0 : filt_d[ACC_W-2 -: OUT_W];
    else
      fmt_word = {~filt_d[ACC_W-1], filt_d[ACC_W-2 -: OUT_W-1]};
  end

  always_comb begin
    word_d = word_q;
    stb_d  = emit;
    if (emit) word_d = fmt_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      stb_q  <= stb_d;
    end
  end

  assign word_o     = word_q;
  assign word_stb_o = stb_q;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned OUT_W  = 24
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              samp_en_i,
  input logic [CODE_W-1:0] code_q,
  input logic [OUT_W-1:0]  word_o,
  input logic              word_stb_o
);
  assert_stb_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    word_stb_o |-> $past(samp_en_i && !sync_i));

  assert_stb_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o);

  assert_no_stb_in_sync_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    sync_i |=> !word_stb_o);

  assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !sync_i |=> $stable(code_q));

  assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !word_stb_o |-> $stable(word_o));
endmodule

bind sinc3_decim sinc3_decim_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .sync_i(sync_i), .samp_en_i(samp_en_i),
  .code_q(code_q), .word_o(word_o), .word_stb_o(word_stb_o)
);

// File: tb/sinc3_decim_tb.sv
`timescale 1ns/1ps
module sinc3_decim_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_i, unipolar_i, samp_en_i, samp_bit_i;
  logic [11:0] code_i;
  logic [23:0] word_o;
  logic        word_stb_o;

  int n_chk = 0, n_fail = 0, n_cyc = 0;

  // reference model state
  longint q1[$], q2[$], q3[$];
  longint s1, s2, s3;
  int     cnt_m, settle_m, code_m;
  logic [23:0] word_m;
  logic        stb_m;

  always #2 clk = ~clk;

  sinc3_decim u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .code_i(code_i),
    .unipolar_i(unipolar_i), .samp_en_i(samp_en_i), .samp_bit_i(samp_bit_i),
    .word_o(word_o), .word_stb_o(word_stb_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt(input longint d, input logic uni);
    if (uni) return (d < 0) ? 24'd0 : 24'(d >>> 12);
    return 24'((d >>> 13) + 64'sd8388608);
  endfunction

  task automatic model_clear(input int n);
    q1.delete(); q2.delete(); q3.delete();
    for (int i = 0; i < n; i++) begin
      q1.push_back(0); q2.push_back(0); q3.push_back(0);
    end
    s1 = 0; s2 = 0; s3 = 0; cnt_m = 0; settle_m = 0;
  endtask

  task automatic model_step(input logic s, input logic e, input logic b);
    longint x;
    stb_m = 1'b0;
    if (s) begin
      code_m = int'(code_i);
      model_clear(code_m);
    end else if (e) begin
      x = b ? 1 : -1;
      s1 += x - q1.pop_front();  q1.push_back(x);
      s2 += s1 - q2.pop_front(); q2.push_back(s1);
      s3 += s2 - q3.pop_front(); q3.push_back(s2);
      cnt_m++;
      if (cnt_m == code_m) begin
        cnt_m = 0;
        if (settle_m == 2) begin
          stb_m  = 1'b1;
          word_m = fmt(s3, unipolar_i);
        end else settle_m++;
      end
    end
  endtask

  // one clock: drive after a falling edge, compare at the next falling edge
  task automatic cyc(input logic s, input logic e, input logic b, input string req);
    sync_i = s; samp_en_i = e; samp_bit_i = b;
    model_step(s, e, b);
    @(negedge clk);
    check({req, " strobe"}, longint'(word_stb_o), longint'(stb_m));
    check({req, " word"}, longint'(word_o), longint'(word_m));
  endtask

  task automatic run_rand(input int n, input int en_pct, input int one_pct, input string req);
    for (int i = 0; i < n; i++)
      cyc(1'b0, ($urandom % 100) < en_pct, ($urandom % 100) < one_pct, req);
  endtask

  task automatic do_sync(input int code, input int len, input string req);
    code_i = 12'(code);
    for (int i = 0; i < len; i++) cyc(1'b1, 1'b1, i[0], req);
  endtask

  // count accepted samples until the first strobe
  task automatic samples_to_stb(input logic b, input int limit, output int got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      cyc(1'b0, 1'b1, b, "R4");
      got++;
      if (word_stb_o) break;
    end
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 200000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int got, hold_w, gap;
    longint fs;
    rst_n = 1'b0; sync_i = 1'b0; samp_en_i = 1'b0; samp_bit_i = 1'b0;
    unipolar_i = 1'b0; code_i = 12'd25;
    code_m = 320; model_clear(320); word_m = '0; stb_m = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset word", longint'(word_o), 0);
    check("R1 reset strobe", longint'(word_stb_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R5: default ratio 320 in force, code_i=25 ignored without sync
    samples_to_stb(1'b1, 2000, got);
    check("R1 default ratio first strobe", got, 960);
    run_rand(700, 100, 50, "R3");

    // R4/R10: sync holds state, word kept, samples ignored
    hold_w = int'(word_o);
    do_sync(20, 4, "R4");
    check("R10 word held through sync", longint'(word_o), hold_w);
    samples_to_stb(1'b0, 200, got);
    check("R4 first strobe after 3N samples", got, 60);
    run_rand(300, 100, 50, "R2");

    // R5: code change without sync does not alter cadence
    code_i = 12'd33;
    gap = 0;
    while (!word_stb_o) cyc(1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 100; i++) begin
      cyc(1'b0, 1'b1, 1'b0, "R5");
      gap++;
      if (word_stb_o) break;
    end
    check("R5 period unchanged", gap, 20);

    // R7/R9: unipolar, gapped enables, positive and clamped
    unipolar_i = 1'b1;
    do_sync(37, 2, "R7");
    run_rand(1500, 50, 75, "R9");
    run_rand(1000, 50, 25, "R7");
    check("R7 clamp to zero", longint'(word_o), 0);

    // R8: unsynchronised step at an odd phase, ratio 200
    unipolar_i = 1'b0;
    do_sync(200, 2, "R8");
    for (int i = 0; i < 1077; i++) cyc(1'b0, 1'b1, 1'b0, "R8");
    got = 0;
    while (got < 4) begin
      cyc(1'b0, 1'b1, 1'b1, "R8");
      if (word_stb_o) got++;
    end
    fs = 64'sd200 * 200 * 200;
    check("R8 fourth word after step", longint'(word_o), 8388608 + (fs >>> 13));

    // R6: minimum ratio all ones, format switch applies per word
    do_sync(19, 1, "R6");
    run_rand(200, 100, 100, "R6");
    check("R6 min ratio full scale", longint'(word_o), 8388608 + (64'sd6859 >>> 13));
    unipolar_i = 1'b1;
    run_rand(60, 100, 100, "R7");
    check("R7 min ratio unipolar", longint'(word_o), 64'sd6859 >>> 12);

    // R2/R6/R7: maximum ratio all ones
    unipolar_i = 1'b0;
    do_sync(4000, 1, "R2");
    samples_to_stb(1'b1, 13000, got);
    fs = 64'sd4000 * 4000 * 4000;
    check("R6 max ratio full scale", longint'(word_o), 8388608 + (fs >>> 13));
    unipolar_i = 1'b1;
    run_rand(4000, 100, 100, "R7");
    check("R7 max ratio unipolar", longint'(word_o), fs >>> 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule